// File: doc/BRIEF.md
# Stereo Serial Audio Input Receiver

This block takes stereo audio from a three-wire serial link and turns it into parallel sample words. The three wires are a bit clock, a frame clock that selects the channel, and a serial data line. All three are sampled in the core clock domain, and the bit clock must be several core cycles per half period. At each rising bit-clock edge the block reads the frame clock level and one data bit. Each channel word is 16 bits of two's complement, sent most significant bit first.

A slot begins when the frame clock level changes. The word is built from the first 16 bits of the slot. Any further bits in the same slot are dropped, so any bit-clock ratio from 32 to 64 times the frame rate can be used. When a right word completes and a full left word was captured before it, both parallel outputs update in the same cycle. A one-cycle valid strobe is raised in that cycle.

Top module: `stereo_rx`

## Requirements
- R1: The first data bit of a slot becomes bit 15 (MSB) of the word and the 16th bit becomes bit 0, giving a two's complement sample.
- R2: Data and frame clock are sampled only at rising bit-clock edges; values present while the bit clock is low or at a falling edge have no effect.
- R3: Frame clock high (1) selects the left word (`left_o`); frame clock low (0) selects the right word (`right_o`).
- R4: A change of frame clock level seen at a rising bit-clock edge starts a new slot, and that edge's data bit is the slot's first bit.
- R5: Bits after the 16th bit of a slot are discarded and leave the captured word unchanged.
- R6: Slots of 16, 20, 24 and 32 bit clocks (32fs to 64fs) all produce correct words.
- R7: `valid_o` is high for exactly one core cycle per completed frame, and `left_o` and `right_o` change in that same cycle.
- R8: A right word yields no strobe unless a complete left word was captured since the last strobe. A slot cut short before 16 bits, and the first partial slot after reset, never complete a word.
- R9: Reset (`rst_ni` low) clears `left_o` and `right_o` to zero and holds `valid_o` low.
- R10: While `valid_o` is low, `left_o` and `right_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| lrck_i | input | 1 | Frame clock, 1 = left, 0 = right |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | 16 | Last complete left sample |
| right_o | output | 16 | Last complete right sample |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench goes after the slot boundary cases:
- Trailing bits in 48fs and 64fs slots carry patterns opposite to the word. A design that keeps shifting past bit 16 returns a word shifted left by the junk.
- A left slot cut to 10 bits is followed by a full right slot. A design that ignores completeness emits a strobe with a stale or partial left word.
- Extreme codes (0x8000, 0x7FFF, 0xFFFF, 0x0001) expose an MSB/LSB reversal or a one-bit offset at the channel change, which would show as a doubled or lost bit.
- Resets in the middle of a run check that both outputs clear at once.

// File: rtl/stereo_rx_pkg.sv
package stereo_rx_pkg;
  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;
endpackage

// File: rtl/stereo_rx_sync.sv
module stereo_rx_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (STAGES == 1) chain_q <= async_i[b];
      else chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/stereo_rx_slot.sv
module stereo_rx_slot
  import stereo_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              lrck_i,
  input  logic              sdata_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output chan_e             chan_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic             bclk_q, rise, started_q, prev_lr_q, lr_change;
  logic [CNT_W-1:0] cnt_q;
  logic [WORD_W-1:0] shift_q;

  assign rise      = bclk_i & ~bclk_q;
  assign lr_change = started_q && (lrck_i != prev_lr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q    <= 1'b0;
      started_q <= 1'b0;
      prev_lr_q <= 1'b0;
      cnt_q     <= CNT_FULL;   // first partial slot is never captured
      shift_q   <= '0;
      done_o    <= 1'b0;
    end else begin
      bclk_q <= bclk_i;
      done_o <= 1'b0;
      if (rise) begin
        started_q <= 1'b1;
        prev_lr_q <= lrck_i;
        if (lr_change) begin
          shift_q <= {{(WORD_W-1){1'b0}}, sdata_i};
          cnt_q   <= CNT_W'(1);
        end else if (started_q && cnt_q < CNT_FULL) begin
          shift_q <= {shift_q[WORD_W-2:0], sdata_i};
          cnt_q   <= cnt_q + CNT_W'(1);
          done_o  <= (cnt_q == CNT_LAST);
        end
      end
    end
  end

  assign word_o = shift_q;
  assign chan_o = chan_e'(prev_lr_q);

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  // R4
  slot_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && lr_change) |=> (cnt_q == CNT_W'(1)));
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/stereo_rx_pair.sv
module stereo_rx_pair
  import stereo_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  input  chan_e             chan_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] left_hold_q;
  logic              left_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold_q <= '0;
      left_ok_q   <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_i) begin
        if (chan_i == CH_LEFT) begin
          left_hold_q <= word_i;
          left_ok_q   <= 1'b1;
        end else begin
          left_ok_q <= 1'b0;
          if (left_ok_q) begin
            left_o  <= left_hold_q;
            right_o <= word_i;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R8
  valid_needs_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && chan_i == CH_RIGHT && !left_ok_q) |=> !valid_o);
  // R3
  valid_on_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(done_i) && $past(chan_i) == CH_RIGHT));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
endmodule

// File: rtl/stereo_rx.sv
module stereo_rx
  import stereo_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              lrck_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic [2:0]        pins_s;
  logic              done;
  logic [WORD_W-1:0] word;
  chan_e             chan;

  // all three pins share one synchronizer depth so their alignment is kept
  stereo_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({bclk_i, lrck_i, sdata_i}),
    .sync_o (pins_s)
  );

  stereo_rx_slot #(.WORD_W(WORD_W)) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_i (pins_s[2]),
    .lrck_i (pins_s[1]),
    .sdata_i(pins_s[0]),
    .done_o (done),
    .word_o (word),
    .chan_o (chan)
  );

  stereo_rx_pair #(.WORD_W(WORD_W)) u_pair (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done),
    .word_i (word),
    .chan_i (chan),
    .left_o (left_o),
    .right_o(right_o),
    .valid_o(valid_o)
  );
endmodule

// File: tb/stereo_rx_tb_top.sv
module stereo_rx_tb_top;
  localparam int HALF  = 4;
  localparam int LIMIT = 150000;

  typedef struct packed {
    logic [6:0]  bits;
    logic [15:0] l;
    logic [15:0] r;
    logic [15:0] fill;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{7'd16, 16'hA5C3, 16'h3C5A, 16'h0000},
    '{7'd16, 16'h8000, 16'h7FFF, 16'h0000},
    '{7'd24, 16'h0001, 16'hFFFF, 16'hFF00},
    '{7'd32, 16'h0000, 16'h0000, 16'hFFFF},
    '{7'd32, 16'hFFFF, 16'h0000, 16'h0000},
    '{7'd20, 16'h1234, 16'h8001, 16'hAAAA},
    '{7'd32, 16'h7FFF, 16'h8000, 16'hC3C3},
    '{7'd32, 16'hC001, 16'h0FF0, 16'h5555}
  };

  logic clk = 1'b0, rst_ni = 1'b0, bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic [15:0] left_o, right_o;
  logic valid_o;
  int checks = 0, errors = 0, pulses = 0;
  logic [15:0] cap_l = '0, cap_r = '0;
  logic prev_valid = 1'b0, wide_err = 1'b0;

  always #4 clk = ~clk;

  stereo_rx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_i(bclk), .lrck_i(lrck),
    .sdata_i(sdata), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      pulses++;
      cap_l = left_o;
      cap_r = right_o;
      if (prev_valid) wide_err = 1'b1;
    end
    prev_valid = valid_o;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2: data and frame clock change only while bclk is low
  task automatic send_slot(input logic lr, input int nbits, input logic [15:0] w,
                           input logic [15:0] fill);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      lrck  = lr;
      sdata = (i < 16) ? w[15-i] : fill[15-((i-16)%16)];
      repeat (HALF) @(negedge clk);
      bclk = 1'b1;
      repeat (HALF) @(negedge clk);
      bclk = 1'b0;
    end
  endtask

  task automatic run_frame(input vec_t v, input string tag);
    int p0;
    p0 = pulses;
    send_slot(1'b1, int'(v.bits), v.l, v.fill);
    send_slot(1'b0, int'(v.bits), v.r, v.fill);
    repeat (10) @(negedge clk);
    check(pulses == p0 + 1, {tag, " R7 one strobe"}, pulses - p0, 1);
    check(cap_l == v.l, {tag, " R1 R3 left word"}, cap_l, v.l);
    check(cap_r == v.r, {tag, " R3 R4 right word"}, cap_r, v.r);
    check(left_o == v.l && right_o == v.r, {tag, " R10 held"}, {left_o, right_o}, {v.l, v.r});
  endtask

  task automatic run_all();
    int p0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(left_o == 0 && right_o == 0 && valid_o == 0, "R9 in reset",
          {left_o, right_o}, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check(left_o == 0 && right_o == 0 && valid_o == 0, "R9 after release",
          {left_o, right_o}, 0);
    // partial right slot first: R8 no strobe without left
    send_slot(1'b0, 4, 16'h0000, 16'h0000);
    check(pulses == 0, "R8 lead-in no strobe", pulses, 0);
    // vector table: R5 trailing bits, R6 ratios
    foreach (VECS[i]) run_frame(VECS[i], (VECS[i].bits > 16) ? "R5 R6 vec" : "R6 vec");
    // R8 short left slot then full right: no strobe, outputs held
    p0 = pulses;
    send_slot(1'b1, 10, 16'h1111, 16'h0000);
    send_slot(1'b0, 16, 16'hBEEF, 16'h0000);
    repeat (10) @(negedge clk);
    check(pulses == p0, "R8 short left no strobe", pulses - p0, 0);
    check(left_o == 16'hC001 && right_o == 16'h0FF0, "R8 R10 outputs held",
          {left_o, right_o}, {16'hC001, 16'h0FF0});
    // R4 recovery after short slot
    run_frame('{7'd32, 16'h6B2D, 16'h94D2, 16'hFFFF}, "R4 recovery");
    // R9 reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check(left_o == 0 && right_o == 0 && valid_o == 0, "R9 mid-run reset",
          {left_o, right_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // first slot after reset is partial and must not count: R8
    send_slot(1'b1, 16, 16'h2222, 16'h0000);
    send_slot(1'b0, 16, 16'h3333, 16'h0000);
    repeat (10) @(negedge clk);
    check(left_o == 0 && right_o == 0, "R8 first slot after reset ignored",
          {left_o, right_o}, 0);
    run_frame('{7'd16, 16'h4321, 16'hFEDC, 16'h0000}, "R1 after reset");
    check(!wide_err, "R7 strobe width", wide_err, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (LIMIT) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected<%0d", LIMIT, LIMIT);
      end
    join_any
    disable fork;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule